// File: doc/BRIEF.md
# Paged Frame-Buffer Host Window

This block connects a PC-style host memory bus to a 512 x 512 frame store of 8-bit pixels (256 KB). The host sees the frame through a 64 KB memory window. A board strap and a select bit in a control port choose where that window sits. Two bits of another control port choose which quarter of the frame the window shows. A rotate bit swaps the row and column halves of the pixel address. With rotate set, consecutive host bytes walk down a vertical line of the image instead of along a horizontal one.

Two write-only 8-bit control ports live on the host I/O bus. A read of the first I/O offset returns a status byte whose top bit is always zero, so software can tell a present board from an empty bus that floats to 0xFF. The window only answers when the RAM-enable bit is set. While that bit is clear the block leaves the memory data bus undriven, so several boards can share one window. The frame store is modelled as a plain single-cycle memory port with combinational read data.

Top module: `fbwin_host_bridge`

## Requirements
- R1: The window occupies host segment (address bits [19:16]) 0xA when strap=0 and select=0, 0xB when strap=1 and select=0, 0xD when strap=0 and select=1, and 0xE when strap=1 and select=1.
- R2: While RAM-enable is clear, no host cycle produces a RAM read or write strobe, and mem_rdata_oe stays low.
- R3: A host cycle whose segment differs from the window segment produces no RAM strobe. A host read that is not answered returns 0xFF on mem_rdata with mem_rdata_oe low.
- R4: With rotate clear, a hit maps to frame address {page, offset[15:0]}, so page selects one of four 64 KB quarters.
- R5: With rotate set, the 18-bit frame address F = {page, offset} with row F[17:9] and column F[8:0] is sent to the RAM as {column, row}. Consecutive offsets therefore step the RAM address by 512.
- R6: Control writes take effect on the next rising clock. I/O offset 0 is control port 0: bits [1:0] hold the page, bit 2 holds rotate, and bits [7:3] are ignored. I/O offset 1 is control port 1: bit 0 holds the window select, bit 1 holds RAM-enable, and bits [7:2] are ignored.
- R7: An I/O read at offset 0 drives io_rdata_oe and returns {7'b0, vblank_in}, which is never 0xFF. I/O reads at other offsets are not driven and return 0xFF, so the control ports cannot be read back.
- R8: Synchronous active-low reset clears both control ports: RAM disabled, page 0, rotate off, low window pair.
- R9: A write to one control port leaves the other port unchanged. Clearing and setting RAM-enable again keeps the page, rotate and select state.
- R10: On a window hit, a host read returns the RAM's read data in the same cycle, and a host write presents mem_wdata as ram_wdata with a one-cycle write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hi | input | 1 | Board strap that selects the upper segment of each window pair |
| vblank_in | input | 1 | Vertical blank flag reported in the status byte |
| io_cs | input | 1 | Board I/O range selected |
| io_ofs | input | 2 | I/O offset within the board range |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0xFF when not driven) |
| io_rdata_oe | output | 1 | I/O read data drive enable |
| mem_addr | input | 20 | Host memory address |
| mem_rd | input | 1 | Host memory read strobe |
| mem_wr | input | 1 | Host memory write strobe |
| mem_wdata | input | 8 | Host memory write data |
| mem_rdata | output | 8 | Host memory read data (0xFF when not driven) |
| mem_rdata_oe | output | 1 | Host memory read data drive enable |
| ram_addr | output | 18 | Frame-store pixel address |
| ram_re | output | 1 | Frame-store read strobe |
| ram_we | output | 1 | Frame-store write strobe |
| ram_wdata | output | 8 | Frame-store write data |
| ram_rdata | input | 8 | Frame-store read data |

## Verification
On every cycle, the assertions check several properties. The bus stays quiet while RAM-enable is clear, and undriven reads float to 0xFF. Hits only fall in one of the four legal segments. The page bits reach the top of the RAM address in straight mode, and the row half receives the page and high offset bits in rotated mode. The assertions also check that a control write lands on the next clock and leaves the other port alone, and that the status byte is never 0xFF. Some behaviours only the bench scenarios can show: the exact strap/select-to-segment table, that ignored control bits change nothing visible, the vertical walk of consecutive rotated offsets, and that page and rotate survive a disable/enable cycle. The bench shows these by comparing full RAM addresses and data against its own model over directed and random traffic.

// File: rtl/fbw_pkg.sv
// Package: shared field positions and I/O offsets for the frame-buffer host window.
// Assumes: the host memory bus carries 20 address bits and the frame is square.
package fbw_pkg;

    // I/O offsets inside the board range
    localparam logic [1:0] IO_OFS_CTL0 = 2'd0;
    localparam logic [1:0] IO_OFS_CTL1 = 2'd1;

    // Control port 1 field positions
    localparam int CP1_SEL_BIT = 0;
    localparam int CP1_EN_BIT  = 1;

    // Status byte width
    localparam int BYTE_W = 8;

endpackage

// File: rtl/fbw_ctrl_ports.sv
// Module: fbw_ctrl_ports
// Holds the two write-only control ports and answers status reads.
// Assumes: single-cycle I/O strobes qualified by io_cs; synchronous active-low reset.
module fbw_ctrl_ports
    import fbw_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic [1:0]        io_ofs,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              vblank_in,
    output logic [PAGE_W-1:0] page,
    output logic              rotate,
    output logic              hi_pair,
    output logic              ram_en,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              io_rdata_oe
);
    localparam int ROT_BIT = PAGE_W;

    logic wr0, wr1;
    logic unused_wbits;

    // Decode writes to each control port
    always_comb begin
        wr0 = io_cs && io_wr && (io_ofs == IO_OFS_CTL0);
        wr1 = io_cs && io_wr && (io_ofs == IO_OFS_CTL1);
    end

    assign unused_wbits = ^io_wdata[BYTE_W-1:ROT_BIT+1];

    // Control port 0: page and rotate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page   <= '0;
            rotate <= 1'b0;
        end else if (wr0) begin
            page   <= io_wdata[PAGE_W-1:0];
            rotate <= io_wdata[ROT_BIT];
        end
    end

    // Control port 1: window select and RAM enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_pair <= 1'b0;
            ram_en  <= 1'b0;
        end else if (wr1) begin
            hi_pair <= io_wdata[CP1_SEL_BIT];
            ram_en  <= io_wdata[CP1_EN_BIT];
        end
    end

    // Status read: only offset 0 is driven, top bit always zero
    always_comb begin
        io_rdata_oe = io_cs && io_rd && (io_ofs == IO_OFS_CTL0);
        io_rdata    = io_rdata_oe ? {{(BYTE_W-1){1'b0}}, vblank_in} : {BYTE_W{1'b1}};
    end

    // R6: a port-0 write lands on the next clock
    assert_cp0_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> (page == $past(io_wdata[PAGE_W-1:0]) && rotate == $past(io_wdata[ROT_BIT])));

    // R9: a port-0 write leaves port 1 alone
    assert_cp1_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && !wr1) |=> (ram_en == $past(ram_en) && hi_pair == $past(hi_pair)));

    // R7: status byte is never all ones
    assert_status_not_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (io_rdata != {BYTE_W{1'b1}}));

endmodule

// File: rtl/fbw_win_decode.sv
// Module: fbw_win_decode
// Matches the host address against the window segment chosen by strap and select.
// Assumes: the window is one naturally aligned segment of 2**WIN_AW bytes.
module fbw_win_decode #(
    parameter int              HOST_AW = 20,
    parameter int              WIN_AW  = 16,
    parameter int              SEG_W   = HOST_AW - WIN_AW,
    parameter logic [SEG_W-1:0] LO_SEG = 4'hA,
    parameter logic [SEG_W-1:0] HI_SEG = 4'hD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] mem_addr,
    input  logic               strap_hi,
    input  logic               hi_pair,
    output logic               hit,
    output logic [WIN_AW-1:0]  offset
);
    logic [SEG_W-1:0] seg;

    // Window segment: pair base plus strap
    always_comb begin
        seg    = (hi_pair ? HI_SEG : LO_SEG) + {{(SEG_W-1){1'b0}}, strap_hi};
        hit    = (mem_addr[HOST_AW-1:WIN_AW] == seg);
        offset = mem_addr[WIN_AW-1:0];
    end

    // R1: a hit only ever falls in one of the four legal segments
    assert_hit_legal_seg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (mem_addr[HOST_AW-1:WIN_AW] == LO_SEG || mem_addr[HOST_AW-1:WIN_AW] == LO_SEG + 1'b1 ||
                 mem_addr[HOST_AW-1:WIN_AW] == HI_SEG || mem_addr[HOST_AW-1:WIN_AW] == HI_SEG + 1'b1));

endmodule

// File: rtl/fbw_pix_xform.sv
// Module: fbw_pix_xform
// Joins page and window offset into a frame address, optionally swapping row and column.
// Assumes: a square frame of 2**PIX_BITS pixels per side.
module fbw_pix_xform #(
    parameter int PIX_BITS = 9,
    parameter int WIN_AW   = 16,
    parameter int FRAME_AW = 2 * PIX_BITS,
    parameter int PAGE_W   = FRAME_AW - WIN_AW
) (
    input  logic [PAGE_W-1:0]   page,
    input  logic [WIN_AW-1:0]   offset,
    input  logic                rotate,
    output logic [FRAME_AW-1:0] frame_addr
);
    logic [FRAME_AW-1:0] linear;
    logic [FRAME_AW-1:0] swapped;

    assign linear = {page, offset};

    // Swap the row half and the column half bit by bit
    for (genvar i = 0; i < PIX_BITS; i++) begin : g_swap
        assign swapped[i]            = linear[i + PIX_BITS];
        assign swapped[i + PIX_BITS] = linear[i];
    end

    // Pick straight or transposed addressing
    always_comb begin
        frame_addr = rotate ? swapped : linear;
    end

endmodule

// File: rtl/fbwin_host_bridge.sv
// Module: fbwin_host_bridge
// Host memory window onto a paged, optionally transposed 512x512 8-bit frame store.
// Assumes: single-cycle host strobes; frame store answers reads combinationally.
module fbwin_host_bridge
    import fbw_pkg::*;
#(
    parameter int HOST_AW  = 20,
    parameter int WIN_AW   = 16,
    parameter int PIX_BITS = 9,
    parameter int DATA_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_hi,
    input  logic                  vblank_in,
    input  logic                  io_cs,
    input  logic [1:0]            io_ofs,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic                  io_rdata_oe,
    input  logic [HOST_AW-1:0]    mem_addr,
    input  logic                  mem_rd,
    input  logic                  mem_wr,
    input  logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_rdata_oe,
    output logic [2*PIX_BITS-1:0] ram_addr,
    output logic                  ram_re,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     ram_wdata,
    input  logic [DATA_W-1:0]     ram_rdata
);
    localparam int FRAME_AW = 2 * PIX_BITS;
    localparam int PAGE_W   = FRAME_AW - WIN_AW;

    logic [PAGE_W-1:0] page;
    logic              rotate, hi_pair, ram_en;
    logic              hit;
    logic [WIN_AW-1:0] offset;
    logic              live;

    fbw_ctrl_ports #(.PAGE_W(PAGE_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_ofs(io_ofs),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .vblank_in(vblank_in),
        .page(page), .rotate(rotate), .hi_pair(hi_pair), .ram_en(ram_en),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
    );

    fbw_win_decode #(.HOST_AW(HOST_AW), .WIN_AW(WIN_AW)) i_dec (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .strap_hi(strap_hi),
        .hi_pair(hi_pair), .hit(hit), .offset(offset)
    );

    fbw_pix_xform #(.PIX_BITS(PIX_BITS), .WIN_AW(WIN_AW)) i_xf (
        .page(page), .offset(offset), .rotate(rotate), .frame_addr(ram_addr)
    );

    // Gate host strobes by window hit and RAM enable
    always_comb begin
        live         = hit && ram_en;
        ram_re       = live && mem_rd;
        ram_we       = live && mem_wr;
        ram_wdata    = mem_wdata;
        mem_rdata_oe = ram_re;
        mem_rdata    = mem_rdata_oe ? ram_rdata : {DATA_W{1'b1}};
    end

    // R2: nothing reaches the RAM or the data bus while disabled
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> (!ram_we && !ram_re && !mem_rdata_oe));

    // R3: an undriven read bus floats high
    assert_float_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rdata_oe |-> (mem_rdata == {DATA_W{1'b1}}));

    // R4: straight mode puts the page at the top of the RAM address
    assert_page_on_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_re || ram_we) && !rotate) |-> (ram_addr[FRAME_AW-1:WIN_AW] == page));

    // R5: rotated mode puts page and high offset bits in the row half
    assert_rotated_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_re || ram_we) && rotate) |->
            (ram_addr[PIX_BITS-1:0] == {page, mem_addr[WIN_AW-1:PIX_BITS]}));

endmodule

// File: tb/test_fbwin_host_bridge.sv
module test_fbwin_host_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hi = 1'b0, vblank_in = 1'b0;
    logic        io_cs = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [1:0]  io_ofs = '0;
    logic [7:0]  io_wdata = '0, io_rdata;
    logic        io_rdata_oe;
    logic [19:0] mem_addr = '0;
    logic        mem_rd = 1'b0, mem_wr = 1'b0;
    logic [7:0]  mem_wdata = '0, mem_rdata;
    logic        mem_rdata_oe;
    logic [17:0] ram_addr;
    logic        ram_re, ram_we;
    logic [7:0]  ram_wdata, ram_rdata;

    int checks = 0, fails = 0;
    logic [7:0] m_cp0 = 8'h00, m_cp1 = 8'h00;

    always #5 clk = ~clk;

    // Frame-store model: data is a fixed pattern of the address
    function automatic logic [7:0] pat(input logic [17:0] a);
        return a[7:0] ^ {a[15:8]} ^ {6'b0, a[17:16]} ^ 8'h5A;
    endfunction
    assign ram_rdata = pat(ram_addr);

    fbwin_host_bridge i_fbwin_host_bridge (.*);

    function automatic logic [3:0] exp_seg(input logic s, input logic sel);
        case ({sel, s})
            2'b00: return 4'hA;
            2'b01: return 4'hB;
            2'b10: return 4'hD;
            default: return 4'hE;
        endcase
    endfunction

    function automatic logic [17:0] exp_ram(input logic [7:0] cp0, input logic [15:0] off);
        logic [17:0] f;
        f = {cp0[1:0], off};
        if (cp0[2]) return {f[8:0], f[17:9]};
        return f;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [1:0] ofs, input logic [7:0] d);
        @(negedge clk);
        io_cs = 1'b1; io_wr = 1'b1; io_ofs = ofs; io_wdata = d;
        @(negedge clk);
        io_cs = 1'b0; io_wr = 1'b0;
        if (ofs == 2'd0) m_cp0 = d;
        if (ofs == 2'd1) m_cp1 = d;
    endtask

    task automatic io_read(input logic [1:0] ofs, input string tag);
        @(negedge clk);
        io_cs = 1'b1; io_rd = 1'b1; io_ofs = ofs;
        #2;
        check(tag, "io_rdata_oe", io_rdata_oe, ofs == 2'd0);
        check(tag, "io_rdata", io_rdata, (ofs == 2'd0) ? {7'b0, vblank_in} : 8'hFF);
        @(negedge clk);
        io_cs = 1'b0; io_rd = 1'b0;
    endtask

    task automatic host(input logic [19:0] a, input logic wr, input logic [7:0] d, input string tag);
        logic        eh;
        logic [17:0] ea;
        @(negedge clk);
        mem_addr = a; mem_wr = wr; mem_rd = !wr; mem_wdata = d;
        #2;
        eh = (a[19:16] == exp_seg(strap_hi, m_cp1[0])) && m_cp1[1];
        ea = exp_ram(m_cp0, a[15:0]);
        check(tag, "ram_we", ram_we, eh && wr);
        check(tag, "ram_re", ram_re, eh && !wr);
        check(tag, "mem_rdata_oe", mem_rdata_oe, eh && !wr);
        if (eh) begin
            check(tag, "ram_addr", ram_addr, ea);
            if (wr) check(tag, "ram_wdata", ram_wdata, d);
            else    check(tag, "mem_rdata", mem_rdata, pat(ea));
        end else if (!wr) begin
            check(tag, "mem_rdata", mem_rdata, 8'hFF);
        end
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: after reset RAM is off, so window A gets no answer
        host(20'hA0010, 1'b0, 8'h00, "R8");
        host(20'hA0020, 1'b1, 8'h33, "R8");
        io_read(2'd0, "R7");
        vblank_in = 1'b1;
        io_read(2'd0, "R7");
        io_read(2'd1, "R7");
        io_read(2'd2, "R7");
        vblank_in = 1'b0;

        // R1, R3: every strap/select combination against every candidate segment
        for (int s = 0; s < 2; s++) begin
            for (int sel = 0; sel < 2; sel++) begin
                strap_hi = s[0];
                io_write(2'd1, {6'b0, 1'b1, sel[0]});
                host({4'hA, 16'h1234}, 1'b0, 8'h00, "R1");
                host({4'hB, 16'h0042}, 1'b0, 8'h00, "R1");
                host({4'hD, 16'hFFFF}, 1'b0, 8'h00, "R1");
                host({4'hE, 16'h8001}, 1'b1, 8'hC3, "R1");
                host({4'hC, 16'h8001}, 1'b0, 8'h00, "R3");
            end
        end

        // R4: each page in straight mode, strap 1 select 1 -> segment E
        for (int p = 0; p < 4; p++) begin
            io_write(2'd0, {6'b0, p[1:0]});
            host(20'hE0000 | 20'(p * 16'h1111), 1'b0, 8'h00, "R4");
            host(20'hEFFFF, 1'b1, 8'h5C, "R10");
        end

        // R5: rotated walk, page 1: consecutive offsets step by 512
        io_write(2'd0, 8'h05);
        for (int k = 0; k < 4; k++) begin
            host(20'hE0000 + 20'(k), 1'b0, 8'h00, "R5");
            checks++;
            if (ram_addr !== 18'(k * 512 + 18'h080)) begin
                fails++;
                $display("FAIL R5 walk: actual %0h expected %0h", ram_addr, k * 512 + 18'h080);
            end
        end

        // R6: ignored upper bits of port 0 (0xF9 = page 1, rotate off)
        io_write(2'd0, 8'hF9);
        host(20'hE4321, 1'b0, 8'h00, "R6");
        // R6: ignored upper bits of port 1 (0xFD = select 1, RAM off)
        io_write(2'd1, 8'hFD);
        host(20'hE4321, 1'b0, 8'h00, "R6");

        // R9: disable then re-enable keeps page 2 and rotate
        io_write(2'd0, 8'h06);
        io_write(2'd1, 8'h03);
        io_write(2'd1, 8'h01);
        host(20'hE1357, 1'b1, 8'hAA, "R2");
        host(20'hE1357, 1'b0, 8'h00, "R2");
        io_write(2'd1, 8'h03);
        host(20'hE1357, 1'b0, 8'h00, "R9");
        io_write(2'd3, 8'hFF);
        host(20'hE2468, 1'b0, 8'h00, "R9");

        // R10: mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [19:0] a;
            r = int'($urandom % 10);
            if (r == 0) io_write(2'd0, 8'($urandom));
            else if (r == 1) io_write(2'd1, 8'($urandom) | ((($urandom % 4) != 0) ? 8'h02 : 8'h00));
            else if (r == 2) strap_hi = ~strap_hi;
            else begin
                if (($urandom % 4) != 0) a = {exp_seg(strap_hi, m_cp1[0]), 16'($urandom)};
                else a = 20'($urandom);
                host(a, 1'($urandom), 8'($urandom), "R10");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule